// File: doc/BRIEF.md
# Byte-Queued SPI Master Shift Engine

This block is an SPI controller that moves eight-bit frames, most significant bit first, between two small queues and the serial pins. Software or a DMA-like agent pushes transmit bytes through a valid/ready port. The engine sends each byte on MOSI and captures one byte from MISO in the same frame. Each captured byte is offered on a valid/ready pop port. A transfer that only reads is made by pushing zero bytes, because every byte sent yields exactly one byte received.

Bit timing comes from a fractional rate generator. The divider input is unsigned fixed point with eight fractional bits. The generator emits tick enables, and one SCK period always spans four ticks, so the divider is set to the system clock divided by four times the wanted SCK rate. Both clock phases are supported. Polarity is applied only as an inversion of the SCK pin, so the internal step sequence is the same for both polarities. When the transmit queue is empty at a frame boundary, the engine parks SCK at its idle level and raises a sticky stall flag. The flag is cleared by a read strobe. A transfer is known to be finished once the transmit queue is empty and the flag is then seen set. Configuration is taken only while the engine is disabled, and enabling starts from a clean step and bit count.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, `sck` and `mosi` are low, `stall_flag` is clear, both queues report empty with level 0, and `tx_ready` is high.
- R2: The tick generator yields floor(m*256/D) ticks in the first m enabled cycles, where D is `cfg_div` and any D below 256 (1.0) counts as 256. One frame takes 32 ticks. With one byte queued before enabling, `stall_flag` is first seen set after exactly ceil(33*D/256) enabled clock edges.
- R3: With `cfg_cpha`=0, MOSI changes only as SCK returns to idle (or before the first edge), and MISO is captured at the edge that takes SCK to its active level. Each step half lasts two ticks.
- R4: With `cfg_cpha`=1, SCK stays idle for one tick while the next bit is taken. MOSI changes at the edge to active, SCK stays active for two ticks, and MISO is captured at the edge back to idle.
- R5: `cfg_cpol`=1 only inverts the SCK pin, so the idle level of `sck` equals `cfg_cpol`. Data timing relative to the leading and trailing edges does not change.
- R6: Frames are eight bits, MSB first on both MOSI and MISO. Each byte taken from the transmit queue produces exactly one byte in the receive queue.
- R7: When the transmit queue is empty at a frame boundary, the engine waits with `sck` at its idle level and sets `stall_flag`.
- R8: A one-cycle `stall_clr` pulse clears `stall_flag`. If a stall is detected in the same cycle, the set takes priority and the flag stays high.
- R9: Changes to `cfg_div`, `cfg_cpha` and `cfg_cpol` have no effect while `enable` is high. Dropping `enable` discards any partial frame, and the next enable starts a fresh frame.
- R10: Each queue holds 4 bytes. A push while full and a pop while empty are ignored, and `*_level`, `*_empty` and `*_full` track the occupancy.
- R11: A new frame starts only if the receive queue has room. While it is full, a queued transmit byte waits, `sck` stays idle, and `stall_flag` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | Run the engine; configuration is captured while low |
| cfg_div | input | 32 | SCK divider, unsigned 24.8, system clocks per tick |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_cpol | input | 1 | SCK idle level |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit queue has room |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_level | output | 3 | Transmit queue occupancy |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | 8 | Oldest received byte |
| rx_ready | input | 1 | Pop the received byte |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_level | output | 3 | Receive queue occupancy |
| stall_flag | output | 1 | Sticky flag: engine waited on an empty transmit queue |
| stall_clr | input | 1 | Read strobe that clears the stall flag |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A wrong step or bit counter shows up within one frame as a byte shifted or rotated on the far side of the link, and the same error shows in the byte that comes back. A slave model on the pins records both directions in every phase and polarity, so such a fault is seen at the first frame boundary. A fault in the tick accumulator moves the cycle in which the stall flag first appears after enabling. That cycle is known exactly for each divider, so a single-cycle drift is visible. Queue pointer or gating faults show as a wrong level or a missing byte within a few cycles of the push or pop that caused them.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int unsigned FRAC_BITS     = 8;
  localparam int unsigned TICKS_PER_BIT = 4;

  // Four tick-steps per bit: A fetch/park, B low or drive, C mid, D close.
  typedef enum logic [1:0] {
    STEP_A = 2'd0,
    STEP_B = 2'd1,
    STEP_C = 2'd2,
    STEP_D = 2'd3
  } step_e;
endpackage

// File: rtl/spi_frac_tick.sv
module spi_frac_tick #(
  parameter int unsigned DIV_W  = 32,
  parameter int unsigned FRAC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int unsigned ACC_W = DIV_W + 1;
  localparam logic [DIV_W-1:0] UNIT = DIV_W'(1) << FRAC_W;

  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] sum, rem;

  always_comb begin
    div_eff = (div < UNIT) ? UNIT : div;
    sum     = {1'b0, acc_q} + {1'b0, UNIT};
    rem     = sum - {1'b0, div_eff};
    tick    = run && (sum >= {1'b0, div_eff});
    if (!run)      acc_d = '0;
    else if (tick) acc_d = rem[DIV_W-1:0];
    else           acc_d = sum[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // Divider of 2.0 or more never yields ticks on consecutive cycles.
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (div_eff[DIV_W-1:FRAC_W+1] != '0)) |=> !tick); // R2

  // The residue always stays below one tick period.
  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (acc_q < div_eff)); // R2
endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic [WIDTH-1:0]                 in_data,
  output logic                             in_ready,
  output logic                             out_valid,
  output logic [WIDTH-1:0]                 out_data,
  input  logic                             out_ready,
  output logic [$clog2(DEPTH+1)-1:0]       level,
  output logic                             empty,
  output logic                             full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [LW-1:0] DEPTH_L  = LW'(DEPTH);

  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0]    lvl_q, lvl_d;
  logic             do_push, do_pop;
  logic [WIDTH-1:0] row_q [DEPTH];

  always_comb begin
    empty     = (lvl_q == '0);
    full      = (lvl_q == DEPTH_L);
    in_ready  = !full;
    out_valid = !empty;
    do_push   = in_valid && !full;
    do_pop    = out_ready && !empty;
    wr_d      = wr_q;
    rd_d      = rd_q;
    lvl_d     = lvl_q;
    if (do_push) wr_d = (wr_q == LAST_IDX) ? '0 : wr_q + AW'(1);
    if (do_pop)  rd_d = (rd_q == LAST_IDX) ? '0 : rd_q + AW'(1);
    if (do_push && !do_pop)      lvl_d = lvl_q + LW'(1);
    else if (do_pop && !do_push) lvl_d = lvl_q - LW'(1);
    out_data = row_q[rd_q];
    level    = lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    logic row_we;
    assign row_we = do_push && (wr_q == AW'(g));
    always_ff @(posedge clk) begin
      if (row_we) row_q[g] <= in_data;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DEPTH_L); // R10

  AST_FULL_DROPS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !out_ready) |=> (level == DEPTH_L)); // R10

  AST_EMPTY_DROPS_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !in_valid) |=> empty); // R10
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_eng_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              cpha,
  input  logic              miso,
  input  logic              tx_avail,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              rx_room,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_word,
  output logic              stall_pulse,
  output logic              sck_int,
  output logic              mosi
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  step_e             step_q, step_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] txsh_q, txsh_d, rxsh_q, rxsh_d, src;
  logic              hold_q, hold_d, sck_q, sck_d, mosi_q, mosi_d;
  logic              frame_start, can_go;

  always_comb begin
    step_d      = step_q;
    cnt_d       = cnt_q;
    txsh_d      = txsh_q;
    rxsh_d      = rxsh_q;
    hold_d      = hold_q;
    sck_d       = sck_q;
    mosi_d      = mosi_q;
    tx_pop      = 1'b0;
    rx_push     = 1'b0;
    stall_pulse = 1'b0;
    rx_word     = {rxsh_q[WORD_W-2:0], miso};
    frame_start = (cnt_q == '0);
    can_go      = !frame_start || (tx_avail && rx_room);
    src         = frame_start ? tx_word : txsh_q;

    if (!run) begin
      step_d = STEP_A;
      cnt_d  = '0;
      txsh_d = '0;
      rxsh_d = '0;
      hold_d = 1'b0;
      sck_d  = 1'b0;
      mosi_d = 1'b0;
    end else if (tick) begin
      unique case (step_q)
        STEP_A: begin
          sck_d = 1'b0;
          if (!can_go) begin
            stall_pulse = frame_start && !tx_avail;
          end else begin
            tx_pop = frame_start;
            hold_d = src[WORD_W-1];
            txsh_d = {src[WORD_W-2:0], 1'b0};
            if (!cpha) mosi_d = src[WORD_W-1];
            step_d = STEP_B;
          end
        end
        STEP_B: begin
          if (cpha) begin
            mosi_d = hold_q;
            sck_d  = 1'b1;
          end
          step_d = STEP_C;
        end
        STEP_C: begin
          if (!cpha) begin
            rxsh_d  = rx_word;
            rx_push = (cnt_q == LAST_BIT);
            sck_d   = 1'b1;
          end
          step_d = STEP_D;
        end
        default: begin
          if (cpha) begin
            rxsh_d  = rx_word;
            rx_push = (cnt_q == LAST_BIT);
            sck_d   = 1'b0;
          end
          cnt_d  = (cnt_q == LAST_BIT) ? '0 : cnt_q + CNT_W'(1);
          step_d = STEP_A;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= STEP_A;
      cnt_q  <= '0;
      txsh_q <= '0;
      rxsh_q <= '0;
      hold_q <= 1'b0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
    end else begin
      step_q <= step_d;
      cnt_q  <= cnt_d;
      txsh_q <= txsh_d;
      rxsh_q <= rxsh_d;
      hold_q <= hold_d;
      sck_q  <= sck_d;
      mosi_q <= mosi_d;
    end
  end

  assign sck_int = sck_q;
  assign mosi    = mosi_q;

  // Phase 0: data never moves while the clock is held active.
  AST_CPHA0_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !cpha && sck_q && $past(sck_q)) |-> $stable(mosi_q)); // R3

  // Phase 1: data never moves while the clock is held idle.
  AST_CPHA1_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && cpha && !sck_q && !$past(sck_q)) |-> $stable(mosi_q)); // R4
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_eng_pkg::*;
#(
  parameter int unsigned DIV_W      = 32,
  parameter int unsigned WORD_W     = 8,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_cpha,
  input  logic              cfg_cpol,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              tx_empty,
  output logic              tx_full,
  output logic [LVL_W-1:0]  tx_level,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  input  logic              rx_ready,
  output logic              rx_empty,
  output logic              rx_full,
  output logic [LVL_W-1:0]  rx_level,
  output logic              stall_flag,
  input  logic              stall_clr,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  logic [1:0]        rst_sync_q;
  logic              rst_s;
  logic [DIV_W-1:0]  div_q;
  logic              cpha_q, cpol_q;
  logic              tick;
  logic              txq_valid, txq_pop, rxq_ready, rxq_push;
  logic [WORD_W-1:0] txq_word, rxq_word;
  logic              stall_pulse, sck_int;
  logic              flag_q, flag_d;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  // Configuration is captured only while the engine is stopped.
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      div_q  <= '0;
      cpha_q <= 1'b0;
      cpol_q <= 1'b0;
    end else if (!enable) begin
      div_q  <= cfg_div;
      cpha_q <= cfg_cpha;
      cpol_q <= cfg_cpol;
    end
  end

  spi_frac_tick #(
    .DIV_W  (DIV_W),
    .FRAC_W (FRAC_BITS)
  ) u_tick (
    .clk   (clk),
    .rst_n (rst_s),
    .run   (enable),
    .div   (div_q),
    .tick  (tick)
  );

  spi_byte_fifo #(
    .WIDTH (WORD_W),
    .DEPTH (FIFO_DEPTH)
  ) u_txq (
    .clk       (clk),
    .rst_n     (rst_s),
    .in_valid  (tx_valid),
    .in_data   (tx_data),
    .in_ready  (tx_ready),
    .out_valid (txq_valid),
    .out_data  (txq_word),
    .out_ready (txq_pop),
    .level     (tx_level),
    .empty     (tx_empty),
    .full      (tx_full)
  );

  spi_byte_fifo #(
    .WIDTH (WORD_W),
    .DEPTH (FIFO_DEPTH)
  ) u_rxq (
    .clk       (clk),
    .rst_n     (rst_s),
    .in_valid  (rxq_push),
    .in_data   (rxq_word),
    .in_ready  (rxq_ready),
    .out_valid (rx_valid),
    .out_data  (rx_data),
    .out_ready (rx_ready),
    .level     (rx_level),
    .empty     (rx_empty),
    .full      (rx_full)
  );

  spi_shift_core #(
    .WORD_W (WORD_W)
  ) u_core (
    .clk         (clk),
    .rst_n       (rst_s),
    .run         (enable),
    .tick        (tick),
    .cpha        (cpha_q),
    .miso        (miso),
    .tx_avail    (txq_valid),
    .tx_word     (txq_word),
    .rx_room     (rxq_ready),
    .tx_pop      (txq_pop),
    .rx_push     (rxq_push),
    .rx_word     (rxq_word),
    .stall_pulse (stall_pulse),
    .sck_int     (sck_int),
    .mosi        (mosi)
  );

  // Sticky stall flag; a detected stall outranks the clearing read.
  always_comb begin
    flag_d = flag_q;
    if (stall_clr)   flag_d = 1'b0;
    if (stall_pulse) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign stall_flag = flag_q;
  assign sck        = sck_int ^ cpol_q;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_s)
    (enable && $past(enable)) |-> ($stable(div_q) && $stable(cpha_q) && $stable(cpol_q))); // R9

  AST_RX_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_s)
    rxq_push |-> rxq_ready); // R11

  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_s)
    txq_pop |-> txq_valid); // R7

  AST_STALL_PARKS_SCK: assert property (@(posedge clk) disable iff (!rst_s)
    stall_pulse |=> (sck == cpol_q)); // R7
endmodule

// File: tb/spi_fifo_master_tb.sv
`timescale 1ns/1ps
module spi_fifo_master_tb_top;
  logic       clk, rst_n, enable;
  logic [31:0] cfg_div;
  logic       cfg_cpha, cfg_cpol;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready, tx_empty, tx_full;
  logic [2:0] tx_level;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_ready, rx_empty, rx_full;
  logic [2:0] rx_level;
  logic       stall_flag, stall_clr;
  logic       sck, mosi, miso;

  int n_tests, n_fail;

  spi_fifo_master dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_div(cfg_div),
    .cfg_cpha(cfg_cpha), .cfg_cpol(cfg_cpol),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .tx_empty(tx_empty), .tx_full(tx_full), .tx_level(tx_level),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_empty(rx_empty), .rx_full(rx_full), .rx_level(rx_level),
    .stall_flag(stall_flag), .stall_clr(stall_clr),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- slave model on the pins ----------------
  logic       b_cpha, b_cpol, slv_clear;
  logic       prev_act, act, miso_r;
  logic [7:0] shin, cur;
  int         kbit, sidx;
  logic [7:0] slave_rx [0:511];
  logic [7:0] got [0:511];

  function automatic logic [7:0] slv_byte(input int i);
    return 8'((i * 53 + 17) ^ 165);
  endfunction

  assign miso = miso_r;

  always @(negedge clk) begin
    act = sck ^ b_cpol;
    if (slv_clear) begin
      kbit = 0; sidx = 0; cur = slv_byte(0); shin = 8'h00;
      miso_r = b_cpha ? 1'b0 : cur[7];
      prev_act = 1'b0;
    end else begin
      if (act && !prev_act) begin
        if (!b_cpha) shin = {shin[6:0], mosi};
        else         miso_r = cur[7 - kbit];
      end else if (!act && prev_act) begin
        if (b_cpha) shin = {shin[6:0], mosi};
        kbit = kbit + 1;
        if (kbit == 8) begin
          slave_rx[sidx] = shin;
          sidx = sidx + 1;
          kbit = 0;
          cur = slv_byte(sidx);
        end
        if (!b_cpha) miso_r = cur[7 - kbit];
      end
      prev_act = act;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input int div, input bit cpha, input bit cpol, input bit run);
    @(negedge clk);
    enable = 1'b0; slv_clear = 1'b1;
    cfg_div = 32'(div); cfg_cpha = cpha; cfg_cpol = cpol;
    b_cpha = cpha; b_cpol = cpol;
    cyc(3);
    slv_clear = 1'b0;
    enable = run;
  endtask

  task automatic push1(input logic [7:0] d);
    @(negedge clk); tx_valid = 1'b1; tx_data = d;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic pop1(output logic [7:0] d, output bit ok);
    @(negedge clk);
    ok = rx_valid; d = rx_data; rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); stall_clr = 1'b1;
    @(negedge clk); stall_clr = 1'b0;
  endtask

  function automatic logic [7:0] tx_pat(input int base, input int step, input int i);
    return 8'(base + i * step);
  endfunction

  task automatic run_xfer(input int n, input int base, input int step, input string tag);
    fork
      begin
        for (int i = 0; i < n; ) begin
          @(negedge clk);
          tx_valid = 1'b1; tx_data = tx_pat(base, step, i);
          if (tx_ready) i++;
        end
        @(negedge clk); tx_valid = 1'b0;
      end
      begin
        for (int j = 0; j < n; ) begin
          @(negedge clk);
          rx_ready = rx_valid;
          if (rx_valid) begin got[j] = rx_data; j++; end
        end
        @(negedge clk); rx_ready = 1'b0;
      end
    join
    cyc(8);
    for (int i = 0; i < n; i++) begin
      chk(got[i] == slv_byte(i), {tag, " rx byte"}, int'(got[i]), int'(slv_byte(i)));
      chk(slave_rx[i] == tx_pat(base, step, i), {tag, " tx byte"},
          int'(slave_rx[i]), int'(tx_pat(base, step, i)));
    end
    chk(sidx == n, {tag, " R6 frame count"}, sidx, n);
    chk(stall_flag == 1'b1, "R7 flag after drain", int'(stall_flag), 1);
    chk(sck == b_cpol, "R7 sck parked idle", int'(sck), int'(b_cpol));
    chk(tx_empty && rx_empty, "R6 queues empty after drain", int'(tx_level), 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] d;
    bit ok;
    int cnt, expc, dv;
    int divs [4];
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; enable = 1'b0; cfg_div = 32'd256; cfg_cpha = 1'b0; cfg_cpol = 1'b0;
    tx_valid = 1'b0; tx_data = 8'h00; rx_ready = 1'b0; stall_clr = 1'b0;
    b_cpha = 1'b0; b_cpol = 1'b0; slv_clear = 1'b1;
    cyc(4);
    rst_n = 1'b1;
    cyc(5);

    // R1 reset state
    chk(sck == 1'b0, "R1 sck", int'(sck), 0);
    chk(mosi == 1'b0, "R1 mosi", int'(mosi), 0);
    chk(stall_flag == 1'b0, "R1 stall flag", int'(stall_flag), 0);
    chk(tx_empty && rx_empty && tx_level == 0 && rx_level == 0, "R1 queues empty",
        int'(tx_level) + int'(rx_level), 0);
    chk(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);

    // R2 tick pacing: first flag after ceil(33*D/256) enabled edges
    divs[0] = 256; divs[1] = 384; divs[2] = 832; divs[3] = 100;
    foreach (divs[q]) begin
      set_cfg(divs[q], 1'b0, 1'b0, 1'b0);
      push1(8'h3C);
      pulse_clr();
      @(negedge clk); enable = 1'b1;
      cnt = 0;
      do begin
        @(posedge clk); cnt++; #1;
      end while (!stall_flag && cnt < 4000);
      dv = (divs[q] < 256) ? 256 : divs[q];
      expc = (33 * dv + 255) / 256;
      chk(cnt == expc, "R2 cycles to first stall", cnt, expc);
      pop1(d, ok);
      chk(ok && d == slv_byte(0), "R2 byte returned", int'(d), int'(slv_byte(0)));
    end

    // R3/R4/R5/R6: all modes, several dividers
    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < 3; v++) begin
        dv = (v == 0) ? 256 : (v == 1) ? 384 : 832;
        set_cfg(dv, m[0], m[1], 1'b1);
        run_xfer(10, m * 40 + v * 7, 37, m[0] ? "R4 R5 cpha1" : "R3 R5 cpha0");
      end
    end

    // R6 full byte sweep, MSB first, mode 0 and mode 3
    set_cfg(256, 1'b0, 1'b0, 1'b1);
    run_xfer(256, 0, 1, "R6 sweep m0");
    set_cfg(256, 1'b1, 1'b1, 1'b1);
    run_xfer(256, 255, 255, "R6 sweep m3");

    // R8 set outranks clear while stalling; clear works when stopped
    set_cfg(256, 1'b0, 1'b0, 1'b1);
    cyc(6);
    chk(stall_flag == 1'b1, "R7 flag while idle-enabled", int'(stall_flag), 1);
    pulse_clr();
    chk(stall_flag == 1'b1, "R8 set wins over clear", int'(stall_flag), 0 + 1);
    @(negedge clk); enable = 1'b0;
    pulse_clr();
    chk(stall_flag == 1'b0, "R8 clear on read", int'(stall_flag), 0);

    // R9 configuration ignored while enabled
    set_cfg(256, 1'b0, 1'b0, 1'b1);
    cyc(6);
    slv_clear = 1'b1;
    cfg_cpol = 1'b1;
    cyc(5);
    chk(sck == 1'b0, "R9 cpol change ignored while enabled", int'(sck), 0);
    enable = 1'b0;
    cyc(3);
    chk(sck == 1'b1, "R5 idle level follows cpol", int'(sck), 1);

    // R9 restart: abort a frame mid-way, next one is whole
    set_cfg(256, 1'b0, 1'b0, 1'b1);
    push1(8'hA7);
    cyc(12);
    set_cfg(256, 1'b0, 1'b0, 1'b1);
    cyc(4);
    chk(rx_level == 0, "R9 aborted frame not delivered", int'(rx_level), 0);
    run_xfer(2, 8'h5A, 3, "R9 restart");

    // R10 push when full and pop when empty are ignored
    set_cfg(256, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) push1(8'(8'h10 + i));
    chk(tx_level == 4, "R10 tx level capped", int'(tx_level), 4);
    chk(tx_full && !tx_ready, "R10 tx full flags", int'(tx_full), 1);
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
    chk(rx_level == 0 && rx_empty, "R10 pop on empty ignored", int'(rx_level), 0);
    enable = 1'b1;
    cyc(4 * 32 + 20);
    chk(rx_level == 4 && rx_full, "R10 rx level", int'(rx_level), 4);
    for (int i = 0; i < 4; i++) begin
      pop1(d, ok);
      chk(ok && d == slv_byte(i), "R10 rx data", int'(d), int'(slv_byte(i)));
      chk(slave_rx[i] == 8'(8'h10 + i), "R10 tx data", int'(slave_rx[i]), 16 + i);
    end
    chk(rx_level == 0 && sidx == 4, "R10 fifth push dropped", sidx, 4);

    // R11 full receive queue holds the next frame back
    set_cfg(256, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) push1(8'(8'hC0 + i));
    cyc(4 * 32 + 20);
    chk(rx_full == 1'b1, "R11 rx full", int'(rx_level), 4);
    push1(8'hE9);
    pulse_clr();
    cyc(100);
    chk(tx_level == 1, "R11 byte held in tx queue", int'(tx_level), 1);
    chk(stall_flag == 1'b0, "R11 no stall flag while rx full", int'(stall_flag), 0);
    chk(sck == 1'b0, "R11 sck idle", int'(sck), 0);
    for (int i = 0; i < 4; i++) begin
      pop1(d, ok);
      chk(ok && d == slv_byte(i), "R11 rx data", int'(d), int'(slv_byte(i)));
    end
    cyc(60);
    pop1(d, ok);
    chk(ok && d == slv_byte(4), "R11 held frame completes", int'(d), int'(slv_byte(4)));
    chk(slave_rx[4] == 8'hE9, "R11 held byte sent", int'(slave_rx[4]), 233);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule